// File: doc/BRIEF.md
# Strided Vector Access Bank Scheduler

This block takes element addresses from two vector access streams and spreads them over seventeen interleaved memory banks. Seventeen is one more than a power of two, so it shares no factor with any power-of-two stride. Such strides therefore visit every bank before they revisit one. The bank of an element is its address modulo seventeen. An exact residue circuit computes it from an alternating sum of 4-bit address digits, with no divider.

Each bank can take one access and then stays occupied for six processor cycles. Accepted requests wait in a sixteen-entry buffer that is kept in age order. In every cycle up to two requests leave the buffer. The oldest request whose bank is free goes first, then the next oldest that targets a different free bank. A young request to a free bank can therefore overtake an older request that is stuck on a busy bank. Each request carries a tag. The tag comes back on a completion lane when the bank access finishes, so tags return in issue order.

A drain input closes the request ports, which lets a vector operation be separated from the next one. Once every buffered request has issued and every completion has been returned, the block reports that it is idle.

Top module: `vec_bank_sched`

## Requirements
- R1: A request with address A drives bit (A mod 17) of `bank_go` in the cycle it issues.
- R2: After a bank is issued to, the same bank is not issued again for the next 5 cycles. A request waiting on that bank issues in the 6th cycle after the earlier issue.
- R3: A younger request to an idle bank issues ahead of an older request that is waiting on a busy bank.
- R4: At most two requests issue per cycle, and they go to distinct banks. Among the requests for one bank, the oldest issues first. Requests accepted in the same cycle are ordered with source 0 older than source 1.
- R5: Take a request accepted at a clock edge whose bank is idle and which has no older competitor for that bank. Its `bank_go` bit is high in the cycle that follows that edge.
- R6: A tag appears on a completion lane exactly 6 cycles after its request issued. Completions follow issue order. When two requests issue in the same cycle, the older one uses lane 0. Lane 1 is only valid when lane 0 is valid.
- R7: The buffer holds 16 requests. `src_ready` is high only when at least 2 slots are free. Every accepted request completes exactly once.
- R8: While `drain_req` is high, `src_ready` is low and no new request is accepted. `idle` goes high in the first cycle in which the buffer is empty and no completion is pending, and it stays high while `drain_req` holds. `idle` is low whenever `drain_req` is low.
- R9: After reset the buffer is empty, `src_ready` is high, and `bank_go`, `cmp_valid` and `idle` are all zero.
- R10: Seventeen consecutive elements with stride 16 reach all 17 banks, one each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 2 | Per-source request valid |
| src_addr | input | 32 | Element addresses, source s in bits [16s+15:16s] |
| src_tag | input | 16 | Request tags, source s in bits [8s+7:8s] |
| src_ready | output | 1 | Both sources may present a request this cycle |
| drain_req | input | 1 | Close the request ports and wait for all work to finish |
| bank_go | output | 17 | One bit per bank, high in the cycle that bank is issued to |
| cmp_valid | output | 2 | Completion lane valid, lane 0 older |
| cmp_tag | output | 16 | Completion tags, lane l in bits [8l+7:8l] |
| idle | output | 1 | Draining and nothing left in flight |

## Verification
The hardest state to reach is a full buffer in which every entry waits on one bank. Only that state makes `src_ready` fall and exposes the strict age order of a long backlog. The bench gets there by driving both sources every cycle with addresses that are all congruent to 9 modulo 17. The bank can then drain just one entry per six cycles, which quickly overwhelms the buffer. The bench then checks that the ready signal drops, that all accepted tags return in acceptance order, and that the gaps between issues are exactly six cycles.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    localparam int ADDR_W    = 16;
    localparam int TAG_W     = 8;
    localparam int BANK_K    = 4;
    localparam int NUM_BANKS = (1 << BANK_K) + 1;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int NUM_DIG   = (ADDR_W + BANK_K - 1) / BANK_K;

    localparam int VBS_NUM_SRC   = 2;
    localparam int VBS_BUF_DEPTH = 16;
    localparam int VBS_BUSY_CYC  = 6;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [BANK_W-1:0] bank_t;

    // one buffered request
    typedef struct packed {
        logic  vld;
        tag_t  tag;
        bank_t bank;
    } slot_t;

    // one issue or completion lane
    typedef struct packed {
        logic vld;
        tag_t tag;
    } done_t;

    // Residue modulo 2^K+1: digit d carries weight (-1)^d.
    function automatic bank_t bank_of(input addr_t a);
        int unsigned       pos;
        int unsigned       neg;
        int unsigned       val;
        logic [BANK_K-1:0] dig;
        pos = 0;
        neg = 0;
        for (int d = 0; d < NUM_DIG; d++) begin
            dig = BANK_K'(a >> (d * BANK_K));
            if ((d % 2) == 0) pos = pos + 32'(dig);
            else              neg = neg + 32'(dig);
        end
        val = pos + 32'(NUM_BANKS * NUM_DIG) - neg;
        for (int r = 0; r < 2 * NUM_DIG; r++) begin
            if (val >= 32'(NUM_BANKS)) val = val - 32'(NUM_BANKS);
        end
        return BANK_W'(val);
    endfunction

endpackage

// File: rtl/vbs_bank_map.sv
module vbs_bank_map
    import vbs_pkg::*;
#(
    parameter int NUM_SRC = VBS_NUM_SRC
)(
    input  logic [NUM_SRC*ADDR_W-1:0] addr,
    output bank_t [NUM_SRC-1:0]       bank
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign bank[s] = bank_of(addr[s*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/vbs_bank_timer.sv
module vbs_bank_timer
    import vbs_pkg::*;
#(
    parameter int BUSY_CYC = VBS_BUSY_CYC
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] go,
    output logic [NUM_BANKS-1:0] busy
);

    localparam int CW = $clog2(BUSY_CYC + 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CW-1:0] remain;
        always_ff @(posedge clk) begin
            if (rst)                remain <= '0;
            else if (go[b])         remain <= CW'(BUSY_CYC - 1);
            else if (remain != '0)  remain <= remain - CW'(1);
        end
        assign busy[b] = (remain != '0);
    end

endmodule

// File: rtl/vbs_req_buffer.sv
module vbs_req_buffer
    import vbs_pkg::*;
#(
    parameter int NUM_SRC   = VBS_NUM_SRC,
    parameter int BUF_DEPTH = VBS_BUF_DEPTH,
    localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
    localparam int IDX_W    = $clog2(BUF_DEPTH)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  slot_t [NUM_SRC-1:0]  push_slot,
    input  logic [NUM_BANKS-1:0] bank_busy,
    output logic [NUM_BANKS-1:0] bank_go,
    output done_t [NUM_SRC-1:0]  issue,
    output logic [CNT_W-1:0]     fill
);

    // index 0 holds the oldest request
    slot_t [BUF_DEPTH-1:0] slots;
    slot_t [BUF_DEPTH-1:0] slots_nxt;
    logic  [BUF_DEPTH-1:0] taken;
    logic  [NUM_BANKS-1:0] claim;
    logic  [CNT_W-1:0]     fill_nxt;

    // oldest-first pick, one bank per lane
    always_comb begin
        taken = '0;
        claim = '0;
        issue = '0;
        for (int l = 0; l < NUM_SRC; l++) begin
            logic             hit;
            logic [IDX_W-1:0] sel;
            hit = 1'b0;
            sel = '0;
            for (int i = 0; i < BUF_DEPTH; i++) begin
                if (!hit && slots[i].vld && !taken[i] &&
                    !bank_busy[slots[i].bank] && !claim[slots[i].bank]) begin
                    hit = 1'b1;
                    sel = IDX_W'(i);
                end
            end
            if (hit) begin
                taken[sel]             = 1'b1;
                claim[slots[sel].bank] = 1'b1;
                issue[l].vld           = 1'b1;
                issue[l].tag           = slots[sel].tag;
            end
        end
    end

    assign bank_go = claim;

    // close the gaps left by issued entries, then append arrivals
    always_comb begin
        logic [CNT_W-1:0] wp;
        slots_nxt = '0;
        wp        = '0;
        for (int i = 0; i < BUF_DEPTH; i++) begin
            if (slots[i].vld && !taken[i]) begin
                if (wp < CNT_W'(BUF_DEPTH)) slots_nxt[IDX_W'(wp)] = slots[i];
                wp = wp + CNT_W'(1);
            end
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (push_slot[s].vld) begin
                if (wp < CNT_W'(BUF_DEPTH)) slots_nxt[IDX_W'(wp)] = push_slot[s];
                wp = wp + CNT_W'(1);
            end
        end
        fill_nxt = wp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
            fill  <= '0;
        end else begin
            slots <= slots_nxt;
            fill  <= fill_nxt;
        end
    end

endmodule

// File: rtl/vbs_cmp_pipe.sv
module vbs_cmp_pipe
    import vbs_pkg::*;
#(
    parameter int NUM_SRC  = VBS_NUM_SRC,
    parameter int BUSY_CYC = VBS_BUSY_CYC
)(
    input  logic                clk,
    input  logic                rst,
    input  done_t [NUM_SRC-1:0] issued,
    output done_t [NUM_SRC-1:0] retired,
    output logic                pending
);

    done_t [NUM_SRC-1:0] stage [BUSY_CYC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < BUSY_CYC; k++) stage[k] <= '0;
        end else begin
            stage[0] <= issued;
            for (int k = 1; k < BUSY_CYC; k++) stage[k] <= stage[k-1];
        end
    end

    assign retired = stage[BUSY_CYC-1];

    always_comb begin
        pending = 1'b0;
        for (int k = 0; k < BUSY_CYC; k++) begin
            for (int l = 0; l < NUM_SRC; l++) pending = pending | stage[k][l].vld;
        end
    end

endmodule

// File: rtl/vec_bank_sched.sv
module vec_bank_sched
    import vbs_pkg::*;
#(
    parameter int NUM_SRC   = VBS_NUM_SRC,
    parameter int BUF_DEPTH = VBS_BUF_DEPTH,
    parameter int BUSY_CYC  = VBS_BUSY_CYC
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC*ADDR_W-1:0] src_addr,
    input  logic [NUM_SRC*TAG_W-1:0]  src_tag,
    output logic                      src_ready,
    input  logic                      drain_req,
    output logic [NUM_BANKS-1:0]      bank_go,
    output logic [NUM_SRC-1:0]        cmp_valid,
    output logic [NUM_SRC*TAG_W-1:0]  cmp_tag,
    output logic                      idle
);

    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    bank_t [NUM_SRC-1:0]  src_bank;
    slot_t [NUM_SRC-1:0]  push_slot;
    done_t [NUM_SRC-1:0]  issued;
    done_t [NUM_SRC-1:0]  retired;
    logic [NUM_BANKS-1:0] bank_busy;
    logic [CNT_W-1:0]     fill;
    logic                 pending;

    assign src_ready = !drain_req && (fill <= CNT_W'(BUF_DEPTH - NUM_SRC));

    vbs_bank_map #(.NUM_SRC(NUM_SRC)) map_i (
        .addr (src_addr),
        .bank (src_bank)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_push
        assign push_slot[s].vld  = src_valid[s] && src_ready;
        assign push_slot[s].tag  = src_tag[s*TAG_W +: TAG_W];
        assign push_slot[s].bank = src_bank[s];
    end

    vbs_req_buffer #(.NUM_SRC(NUM_SRC), .BUF_DEPTH(BUF_DEPTH)) buf_i (
        .clk       (clk),
        .rst       (rst),
        .push_slot (push_slot),
        .bank_busy (bank_busy),
        .bank_go   (bank_go),
        .issue     (issued),
        .fill      (fill)
    );

    vbs_bank_timer #(.BUSY_CYC(BUSY_CYC)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .go   (bank_go),
        .busy (bank_busy)
    );

    vbs_cmp_pipe #(.NUM_SRC(NUM_SRC), .BUSY_CYC(BUSY_CYC)) cmp_i (
        .clk     (clk),
        .rst     (rst),
        .issued  (issued),
        .retired (retired),
        .pending (pending)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign cmp_valid[s]                 = retired[s].vld;
        assign cmp_tag[s*TAG_W +: TAG_W]    = retired[s].tag;
    end

    assign idle = drain_req && (fill == '0) && !pending;

endmodule

// File: rtl/vbs_checker.sv
module vbs_checker
    import vbs_pkg::*;
#(
    parameter int NUM_SRC   = VBS_NUM_SRC,
    parameter int BUF_DEPTH = VBS_BUF_DEPTH,
    parameter int BUSY_CYC  = VBS_BUSY_CYC
)(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_SRC-1:0]   src_valid,
    input logic                 src_ready,
    input logic                 drain_req,
    input logic [NUM_BANKS-1:0] bank_go,
    input logic [NUM_SRC-1:0]   cmp_valid,
    input logic                 idle
);

    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    logic [15:0] held;
    logic [15:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            inflight <= '0;
        end else begin
            held     <= held + 16'($countones(src_valid & {NUM_SRC{src_ready}}))
                             - 16'($countones(bank_go));
            inflight <= inflight + 16'($countones(bank_go))
                                 - 16'($countones(cmp_valid));
        end
    end

    AST_DRAIN_CLOSES: assert property (@(posedge clk) disable iff (rst) drain_req |-> !src_ready); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) idle |-> (drain_req && bank_go == '0 && cmp_valid == '0)); // R8
    AST_ISSUE_WIDTH: assert property (@(posedge clk) disable iff (rst) $countones(bank_go) <= NUM_SRC); // R4
    AST_LANE_PACKED: assert property (@(posedge clk) disable iff (rst) (cmp_valid & (cmp_valid + ONE)) == '0); // R6
    AST_CMP_HAS_ISSUE: assert property (@(posedge clk) disable iff (rst) 16'($countones(cmp_valid)) <= inflight); // R6
    AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (rst) held <= 16'(BUF_DEPTH)); // R7

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
        logic [7:0] gap;
        always_ff @(posedge clk) begin
            if (rst)             gap <= '0;
            else if (bank_go[b]) gap <= 8'(BUSY_CYC - 1);
            else if (gap != '0)  gap <= gap - 8'd1;
        end
        AST_BANK_GAP: assert property (@(posedge clk) disable iff (rst) bank_go[b] |-> gap == '0); // R2
    end

endmodule

bind vec_bank_sched vbs_checker #(
    .NUM_SRC   (NUM_SRC),
    .BUF_DEPTH (BUF_DEPTH),
    .BUSY_CYC  (BUSY_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .drain_req (drain_req),
    .bank_go   (bank_go),
    .cmp_valid (cmp_valid),
    .idle      (idle)
);

// File: tb/vec_bank_sched_tb_top.sv
module vec_bank_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int S  = 2;
    localparam int AW = 16;
    localparam int TW = 8;
    localparam int NB = 17;

    logic          clk;
    logic          rst;
    logic [S-1:0]  src_valid;
    logic [S*AW-1:0] src_addr;
    logic [S*TW-1:0] src_tag;
    logic          src_ready;
    logic          drain_req;
    logic [NB-1:0] bank_go;
    logic [S-1:0]  cmp_valid;
    logic [S*TW-1:0] cmp_tag;
    logic          idle;

    int n_chk;
    int n_fail;
    int cyc;
    int go_b[$];
    int go_c[$];
    int cmp_t[$];
    int cmp_c[$];

    vec_bank_sched dut_i (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_addr(src_addr),
        .src_tag(src_tag), .src_ready(src_ready), .drain_req(drain_req),
        .bank_go(bank_go), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .idle(idle)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    // event logs, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int b = 0; b < NB; b++) begin
                if (bank_go[b]) begin
                    go_b.push_back(b);
                    go_c.push_back(cyc);
                end
            end
            for (int l = 0; l < S; l++) begin
                if (cmp_valid[l]) begin
                    cmp_t.push_back(int'(cmp_tag[l*TW +: TW]));
                    cmp_c.push_back(cyc);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int s, input int a, input int t);
        src_valid[s]             = 1'b1;
        src_addr[s*AW +: AW]     = AW'(a);
        src_tag[s*TW +: TW]      = TW'(t);
    endtask

    task automatic clear_logs;
        go_b.delete(); go_c.delete(); cmp_t.delete(); cmp_c.delete();
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic test_reset;
        chk("R9 ready", int'(src_ready), 1);
        chk("R9 bank_go", int'(bank_go), 0);
        chk("R9 cmp_valid", int'(cmp_valid), 0);
        chk("R9 idle", int'(idle), 0);
    endtask

    task automatic test_stride;
        int n0;
        int mask;
        clear_logs();
        n0 = cyc;
        for (int i = 0; i < 17; i++) begin
            put(0, 3 + 16 * i, i);
            @(negedge clk);
        end
        src_valid = '0;
        repeat (12) @(negedge clk);
        chk("R1 issue count", go_b.size(), 17);
        mask = 0;
        for (int i = 0; i < 17 && i < go_b.size(); i++) begin
            chk("R1 bank index", go_b[i], (3 + 16 * i) % 17);
            chk("R5 issue cycle", go_c[i], n0 + 1 + i);
            mask = mask | (1 << go_b[i]);
        end
        chk("R10 all banks reached", mask, (1 << 17) - 1);
        chk("R6 completion count", cmp_t.size(), 17);
        for (int i = 0; i < 17 && i < cmp_t.size() && i < go_c.size(); i++) begin
            chk("R6 tag order", cmp_t[i], i);
            chk("R6 latency", cmp_c[i] - go_c[i], 6);
        end
    endtask

    task automatic test_bypass;
        int n0;
        clear_logs();
        n0 = cyc;
        put(0, 0, 40);
        put(1, 17, 41);
        @(negedge clk);
        src_valid = '0;
        put(0, 1, 42);
        @(negedge clk);
        src_valid = '0;
        repeat (15) @(negedge clk);
        chk("R3 issue count", go_b.size(), 3);
        if (go_b.size() == 3) begin
            chk("R5 first bank", go_b[0], 0);
            chk("R5 first cycle", go_c[0], n0 + 1);
            chk("R3 bypass bank", go_b[1], 1);
            chk("R3 bypass cycle", go_c[1], n0 + 2);
            chk("R2 waiting bank", go_b[2], 0);
            chk("R2 waiting cycle", go_c[2], n0 + 7);
        end
        chk("R6 completion count", cmp_t.size(), 3);
        if (cmp_t.size() == 3) begin
            chk("R3 completion 0", cmp_t[0], 40);
            chk("R3 completion 1", cmp_t[1], 42);
            chk("R3 completion 2", cmp_t[2], 41);
            chk("R6 last completion cycle", cmp_c[2], n0 + 13);
        end
    endtask

    task automatic test_dual;
        int n0;
        clear_logs();
        n0 = cyc;
        put(0, 2, 50);
        put(1, 5, 51);
        @(negedge clk);
        src_valid = '0;
        repeat (9) @(negedge clk);
        chk("R4 dual issue count", go_b.size(), 2);
        if (go_b.size() == 2) begin
            chk("R4 dual cycle a", go_c[0], n0 + 1);
            chk("R4 dual cycle b", go_c[1], n0 + 1);
        end
        if (cmp_t.size() == 2) begin
            chk("R6 lane0 older", cmp_t[0], 50);
            chk("R6 lane1 younger", cmp_t[1], 51);
            chk("R6 same-cycle completion", cmp_c[1] - cmp_c[0], 0);
        end else chk("R6 dual completion count", cmp_t.size(), 2);

        clear_logs();
        n0 = cyc;
        put(0, 7, 60);
        put(1, 24, 61);
        @(negedge clk);
        put(0, 41, 62);
        put(1, 8, 63);
        @(negedge clk);
        src_valid = '0;
        repeat (22) @(negedge clk);
        chk("R4 same-bank count", cmp_t.size(), 4);
        if (cmp_t.size() == 4) begin
            chk("R4 order 0", cmp_t[0], 60);
            chk("R3 order 1", cmp_t[1], 63);
            chk("R4 order 2", cmp_t[2], 61);
            chk("R4 order 3", cmp_t[3], 62);
            chk("R2 third issue cycle", cmp_c[3] - 6, n0 + 13);
        end
    endtask

    task automatic test_backpressure;
        int acc;
        int saw_low;
        int bad;
        clear_logs();
        acc = 0;
        saw_low = 0;
        for (int it = 0; it < 24; it++) begin
            if (src_ready) begin
                put(0, 9 + 17 * acc, 100 + acc);
                put(1, 9 + 17 * (acc + 1), 101 + acc);
                acc = acc + 2;
            end else begin
                src_valid = '0;
                saw_low = 1;
            end
            @(negedge clk);
        end
        src_valid = '0;
        repeat (acc * 6 + 20) @(negedge clk);
        chk("R7 ready dropped on full buffer", saw_low, 1);
        chk("R7 every request completed", cmp_t.size(), acc);
        bad = 0;
        for (int i = 0; i < cmp_t.size(); i++) if (cmp_t[i] != 100 + i) bad++;
        chk("R4 backlog age order mismatches", bad, 0);
        bad = 0;
        for (int i = 1; i < go_c.size(); i++) if (go_c[i] - go_c[i-1] != 6) bad++;
        chk("R2 backlog spacing mismatches", bad, 0);
    endtask

    task automatic test_drain;
        int n0;
        int first_idle;
        int drop;
        clear_logs();
        n0 = cyc;
        put(0, 11, 200);
        put(1, 28, 201);
        @(negedge clk);
        src_valid = '0;
        put(0, 12, 210);
        drain_req = 1'b1;
        #1;
        chk("R8 ready low while draining", int'(src_ready), 0);
        first_idle = -1;
        drop = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            #1;
            if (idle && first_idle < 0) first_idle = cyc;
            if (!idle && first_idle >= 0) drop = 1;
        end
        chk("R8 idle first cycle", first_idle, n0 + 14);
        chk("R8 idle held", drop, 0);
        chk("R8 blocked request never issued", go_b.size(), 2);
        chk("R8 completions during drain", cmp_t.size(), 2);
        src_valid = '0;
        drain_req = 1'b0;
        #1;
        chk("R8 idle low without drain", int'(idle), 0);
        chk("R8 ready back", int'(src_ready), 1);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        cyc = 0;
        rst = 1'b1;
        src_valid = '0;
        src_addr = '0;
        src_tag = '0;
        drain_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_stride();
        test_bypass();
        test_dual();
        test_backpressure();
        test_drain();
        finish_run();
    end

endmodule